// File: doc/BRIEF.md
# Time-Stepped Leaky Integrate-and-Fire Neuron Array

This block updates a small group of integer spiking neurons one timestep at a time. Each neuron has a signed membrane voltage and its own configuration: three synaptic weights, a leak and a firing threshold. During a timestep a stream of synaptic events arrives. Each event names a neuron and a two-bit axon type, and the type picks which of that neuron's three weights is added to its voltage. A one-cycle `tick` closes the step. At the tick every neuron subtracts its leak and compares the result with its threshold. A neuron above threshold fires a one-cycle spike and restarts from zero. Any other negative result is raised to zero.

All parameters are loaded through a write port while `cfg_mode` is held high, and the voltages are held at zero for as long as that mode lasts. All arithmetic is integer and saturating, so the outputs match a plain software model bit for bit. A read port selects one neuron and shows its present voltage so that the host can observe it.

Top module: `lif_neuron_array`

## Requirements
- R1: Out of reset every voltage reads 0 and every spike bit is 0.
- R2: A write takes effect only when `cfg_mode` and `cfg_we` are both high. It updates neuron `cfg_neuron`, field `cfg_field`, with these codes: 0, 1 and 2 select the weight of axon type 0, 1 and 2 (taken from the low 9 bits, signed); 3 selects the leak (low 9 bits, signed); 4 selects the threshold (16 bits, signed). A write while `cfg_mode` is low changes nothing.
- R3: While `cfg_mode` is high, every voltage is forced to 0 on the next edge, no spike is produced, and synaptic events and ticks have no effect.
- R4: An event with `ev_valid` high and type 0, 1 or 2 adds the weight of that type to the voltage of neuron `ev_neuron`, visible one cycle later. The other neurons do not change.
- R5: An event of type 3 is ignored.
- R6: Every addition saturates at +32767 and -32768 instead of wrapping. This includes the leak subtraction.
- R7: At a tick each neuron computes its voltage minus its leak. It fires only if that value is strictly greater than its threshold. The spike bit is high for exactly the one cycle after the tick edge.
- R8: A neuron that fires restarts its voltage at 0.
- R9: A value that is below zero at the end of a step is clamped to 0.
- R10: An event in the same cycle as the tick belongs to the next step. It is added to the post-step voltage, after the reset or clamp.
- R11: `vm_value` shows, combinationally, the voltage of the neuron selected by `vm_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode; voltages held at zero |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_neuron | input | 2 | Neuron index for the write |
| cfg_field | input | 3 | Field code (0..2 weight, 3 leak, 4 threshold) |
| cfg_data | input | 16 | Write data |
| tick | input | 1 | Ends the current timestep |
| ev_valid | input | 1 | Synaptic event present |
| ev_neuron | input | 2 | Target neuron of the event |
| ev_type | input | 2 | Axon type of the event (3 = none) |
| spike | output | 4 | One bit per neuron, pulse after a firing tick |
| vm_sel | input | 2 | Voltage read select |
| vm_value | output | 16 | Voltage of the selected neuron |

## Verification
The bench sets a voltage to exactly the threshold after leak, which catches a `>=` comparison: such a design would fire where no spike is expected. It drives a neuron past both signed limits and then applies a negative leak at the top limit. A wrapping adder would turn these into large values of the opposite sign and trigger false spikes. An event placed in the tick cycle checks that it survives the reset after a spike; a design that drops it or adds it before the compare reads 0 or misses the spike. A write made outside configuration mode lowers a threshold, so a design that honours it fires early.

// File: rtl/lif_pkg.sv
// Package: shared codes for the neuron array.
// Assumes: field codes and the idle axon type are fixed by the block spec.
package lif_pkg;
    // Selects which per-neuron parameter a configuration write updates.
    typedef enum logic [2:0] {
        FLD_W0   = 3'd0,
        FLD_W1   = 3'd1,
        FLD_W2   = 3'd2,
        FLD_LEAK = 3'd3,
        FLD_THR  = 3'd4
    } cfg_field_e;

    // Axon type code that carries no synaptic weight.
    localparam logic [1:0] AXON_IDLE = 2'd3;
endpackage

// File: rtl/lif_sat_add.sv
// Module: signed saturating adder.
// Adds a narrower signed operand to a wider one and clips the sum to the
// range of the wider operand. Assumes B_W <= A_W.
module lif_sat_add #(
    parameter int A_W = 16,
    parameter int B_W = 10
) (
    input  logic signed [A_W-1:0] a,
    input  logic signed [B_W-1:0] b,
    output logic signed [A_W-1:0] y
);
    localparam logic signed [A_W-1:0] MAX_V = {1'b0, {(A_W-1){1'b1}}};
    localparam logic signed [A_W-1:0] MIN_V = {1'b1, {(A_W-1){1'b0}}};

    logic signed [A_W:0] wide;

    // Widen both operands by sign extension and clip on overflow.
    always_comb begin
        wide = $signed({a[A_W-1], a}) + $signed({{(A_W+1-B_W){b[B_W-1]}}, b});
        if (wide[A_W] != wide[A_W-1])
            y = wide[A_W] ? MIN_V : MAX_V;
        else
            y = wide[A_W-1:0];
    end
endmodule

// File: rtl/lif_param_bank.sv
// Module: parameter registers of one neuron.
// Holds three weights, a leak and a threshold. wr_en must already be
// qualified with configuration mode and the neuron index by the parent.
module lif_param_bank
    import lif_pkg::*;
#(
    parameter int V_W = 16,
    parameter int W_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            field,
    input  logic [V_W-1:0]        data,
    output logic signed [W_W-1:0] w0,
    output logic signed [W_W-1:0] w1,
    output logic signed [W_W-1:0] w2,
    output logic signed [W_W-1:0] leak,
    output logic signed [V_W-1:0] thr
);
    cfg_field_e fsel;

    // Interpret the raw field code.
    always_comb fsel = cfg_field_e'(field);

    // Store one parameter per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w0   <= '0;
            w1   <= '0;
            w2   <= '0;
            leak <= '0;
            thr  <= '0;
        end else if (wr_en) begin
            case (fsel)
                FLD_W0:   w0   <= data[W_W-1:0];
                FLD_W1:   w1   <= data[W_W-1:0];
                FLD_W2:   w2   <= data[W_W-1:0];
                FLD_LEAK: leak <= data[W_W-1:0];
                FLD_THR:  thr  <= data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/lif_neuron_core.sv
// Module: membrane state and step update of one neuron.
// Between ticks it adds the selected weight per event. At a tick it
// subtracts the leak, compares with the threshold strictly, then resets
// or clamps. An event in the tick cycle is added after the step result.
module lif_neuron_core
    import lif_pkg::*;
#(
    parameter int V_W = 16,
    parameter int W_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_mode,
    input  logic                  tick,
    input  logic                  ev_hit,
    input  logic [1:0]            ev_type,
    input  logic signed [W_W-1:0] w0,
    input  logic signed [W_W-1:0] w1,
    input  logic signed [W_W-1:0] w2,
    input  logic signed [W_W-1:0] leak,
    input  logic signed [V_W-1:0] thr,
    output logic signed [V_W-1:0] v,
    output logic                  spike
);
    localparam int L_W = W_W + 1;

    logic signed [W_W-1:0] w_sel;
    logic signed [W_W-1:0] ev_add;
    logic signed [L_W-1:0] neg_leak;
    logic signed [V_W-1:0] after_leak;
    logic signed [V_W-1:0] step_v;
    logic signed [V_W-1:0] base_v;
    logic signed [V_W-1:0] v_next;
    logic                  fire;

    // Pick the weight named by the axon type.
    always_comb begin
        case (ev_type)
            2'd0:    w_sel = w0;
            2'd1:    w_sel = w1;
            2'd2:    w_sel = w2;
            default: w_sel = '0;
        endcase
        ev_add = ev_hit ? w_sel : '0;
    end

    // Negate the leak in a field one bit wider so -min fits.
    always_comb neg_leak = -$signed({leak[W_W-1], leak});

    lif_sat_add #(.A_W(V_W), .B_W(L_W)) u_leak_add (
        .a (v),
        .b (neg_leak),
        .y (after_leak)
    );

    // Threshold compare, reset on fire, clamp below zero.
    always_comb begin
        fire   = after_leak > thr;
        if (fire || after_leak[V_W-1])
            step_v = '0;
        else
            step_v = after_leak;
        base_v = tick ? step_v : v;
    end

    lif_sat_add #(.A_W(V_W), .B_W(W_W)) u_ev_add (
        .a (base_v),
        .b (ev_add),
        .y (v_next)
    );

    // Membrane voltage and spike pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_mode) begin
            v     <= '0;
            spike <= 1'b0;
        end else begin
            v     <= v_next;
            spike <= tick & fire;
        end
    end
endmodule

// File: rtl/lif_neuron_array.sv
// Module: top of the leaky integrate-and-fire neuron array.
// Decodes configuration writes and synaptic events per neuron and exposes
// one voltage through a read select. Assumes one event per cycle.
module lif_neuron_array
    import lif_pkg::*;
#(
    parameter int N_NEURONS = 4,
    parameter int V_W       = 16,
    parameter int W_W       = 9,
    parameter int IDX_W     = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_mode,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_neuron,
    input  logic [2:0]            cfg_field,
    input  logic [V_W-1:0]        cfg_data,
    input  logic                  tick,
    input  logic                  ev_valid,
    input  logic [IDX_W-1:0]      ev_neuron,
    input  logic [1:0]            ev_type,
    output logic [N_NEURONS-1:0]  spike,
    input  logic [IDX_W-1:0]      vm_sel,
    output logic signed [V_W-1:0] vm_value
);
    logic signed [V_W-1:0]       volt [N_NEURONS];
    logic [N_NEURONS*V_W-1:0]    volt_bus;
    logic                        ev_ok;

    // An event carries a weight only for the three real axon types.
    always_comb ev_ok = ev_valid && (ev_type != AXON_IDLE);

    for (genvar i = 0; i < N_NEURONS; i++) begin : g_neuron
        logic                  wr_en;
        logic                  ev_hit;
        logic signed [W_W-1:0] w0, w1, w2, leak;
        logic signed [V_W-1:0] thr;

        // Per-neuron decode of writes and events.
        always_comb begin
            wr_en  = cfg_mode && cfg_we && (cfg_neuron == IDX_W'(i));
            ev_hit = ev_ok && (ev_neuron == IDX_W'(i));
        end

        lif_param_bank #(.V_W(V_W), .W_W(W_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .field (cfg_field),
            .data  (cfg_data),
            .w0    (w0),
            .w1    (w1),
            .w2    (w2),
            .leak  (leak),
            .thr   (thr)
        );

        lif_neuron_core #(.V_W(V_W), .W_W(W_W)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_mode (cfg_mode),
            .tick     (tick),
            .ev_hit   (ev_hit),
            .ev_type  (ev_type),
            .w0       (w0),
            .w1       (w1),
            .w2       (w2),
            .leak     (leak),
            .thr      (thr),
            .v        (volt[i]),
            .spike    (spike[i])
        );

        // Flatten voltages for the read mux and the checker.
        assign volt_bus[i*V_W +: V_W] = volt[i];
    end

    // Voltage read port.
    always_comb begin
        if (int'(vm_sel) < N_NEURONS)
            vm_value = volt_bus[int'(vm_sel)*V_W +: V_W];
        else
            vm_value = '0;
    end
endmodule

// File: rtl/lif_checker.sv
// Module: temporal checks on the neuron array, bound to the top.
// Assumes the synchronous active-low reset of the top.
module lif_checker #(
    parameter int N   = 4,
    parameter int V_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_mode,
    input logic             tick,
    input logic             ev_valid,
    input logic [N-1:0]     spike,
    input logic [N*V_W-1:0] volt_bus
);
    // R3: configuration mode clears all state on the next edge.
    a_r3_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |=> (volt_bus == '0 && spike == '0));

    // R7: a spike can only follow a tick.
    a_r7_spike_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (spike == '0));

    // R4: with no event, tick or configuration, voltages hold.
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ev_valid && !cfg_mode) |=> $stable(volt_bus));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R9: a step without a trailing event leaves no negative voltage.
        a_r9_no_negative: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !ev_valid && !cfg_mode) |=> !volt_bus[i*V_W + V_W - 1]);

        // R8: a firing neuron restarts at zero.
        a_r8_zero_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !ev_valid && !cfg_mode) |=>
                (!spike[i] || volt_bus[i*V_W +: V_W] == '0));
    end
endmodule

bind lif_neuron_array lif_checker #(.N(N_NEURONS), .V_W(V_W)) u_lif_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .tick     (tick),
    .ev_valid (ev_valid),
    .spike    (spike),
    .volt_bus (volt_bus)
);

// File: tb/test_lif_neuron_array.sv
// Directed bench for the neuron array; one task per scenario.
module test_lif_neuron_array;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_mode = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_neuron = '0;
    logic [2:0]        cfg_field = '0;
    logic [15:0]       cfg_data = '0;
    logic              tick = 1'b0;
    logic              ev_valid = 1'b0;
    logic [1:0]        ev_neuron = '0;
    logic [1:0]        ev_type = '0;
    logic [3:0]        spike;
    logic [1:0]        vm_sel = '0;
    logic signed [15:0] vm_value;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lif_neuron_array i_lif_neuron_array (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
        .cfg_neuron(cfg_neuron), .cfg_field(cfg_field), .cfg_data(cfg_data),
        .tick(tick), .ev_valid(ev_valid), .ev_neuron(ev_neuron),
        .ev_type(ev_type), .spike(spike), .vm_sel(vm_sel), .vm_value(vm_value)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic get_v(int n, output int v);
        vm_sel = 2'(n);
        #0.5;
        v = int'(vm_value);
    endtask

    task automatic wr(int n, int f, int d);
        cfg_we = 1'b1; cfg_neuron = 2'(n); cfg_field = 3'(f); cfg_data = 16'(d);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic ev(int n, int t);
        ev_valid = 1'b1; ev_neuron = 2'(n); ev_type = 2'(t);
        @(posedge clk); #1;
        ev_valid = 1'b0;
    endtask

    // Tick for one cycle and return the spike bits seen after the edge.
    task automatic do_tick(output logic [3:0] sp);
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
        sp = spike;
    endtask

    task automatic t_reset();
        int v;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        chk("R1", "spike after reset", int'(spike), 0);
        for (int i = 0; i < 4; i++) begin
            get_v(i, v);
            chk("R1", "voltage after reset", v, 0);
        end
    endtask

    task automatic t_config();
        int v;
        cfg_mode = 1'b1;
        // Neuron 0: weights 10, 3, -7; leak 2; threshold 20.
        wr(0, 0, 10); wr(0, 1, 3); wr(0, 2, -7); wr(0, 3, 2); wr(0, 4, 20);
        // Neuron 1: weight 50, leak 0, threshold 40.
        wr(1, 0, 50); wr(1, 4, 40);
        // Neuron 2: weight 255, leak -1, threshold 32767.
        wr(2, 0, 255); wr(2, 3, -1); wr(2, 4, 32767);
        // Neuron 3: type-2 weight -256, leak 5, threshold 100.
        wr(3, 2, -256); wr(3, 3, 5); wr(3, 4, 100);
        cfg_mode = 1'b0;
        // R2: this write is outside configuration mode and must be dropped.
        wr(0, 4, 0);
        get_v(0, v);
        chk("R2", "voltage after config", v, 0);
    endtask

    task automatic t_integrate();
        int v;
        ev(0, 0); get_v(0, v); chk("R4", "type0 add", v, 10);
        ev(0, 1); get_v(0, v); chk("R4", "type1 add", v, 13);
        ev(0, 2); get_v(0, v); chk("R4", "type2 add", v, 6);
        get_v(1, v); chk("R4", "other neuron unchanged", v, 0);
        ev(0, 3); get_v(0, v); chk("R5", "type3 ignored", v, 6);
        chk("R11", "read port value", int'(vm_value), 6);
    endtask

    task automatic t_threshold();
        int v;
        logic [3:0] sp;
        do_tick(sp);
        // 6 - 2 = 4; a threshold wrongly written to 0 would fire here.
        chk("R2", "no spike at 4 vs 20", int'(sp), 0);
        get_v(0, v); chk("R7", "leak applied", v, 4);
        ev(0, 0); ev(0, 1); ev(0, 1); ev(0, 1);
        do_tick(sp);
        chk("R7", "spike above threshold", int'(sp), 1);
        get_v(0, v); chk("R8", "reset after spike", v, 0);
        @(posedge clk); #1;
        chk("R7", "spike lasts one cycle", int'(spike), 0);
        ev(0, 0); ev(0, 0); ev(0, 1); ev(0, 2); ev(0, 1); ev(0, 1);
        do_tick(sp);
        chk("R7", "no spike at equal threshold", int'(sp), 0);
        get_v(0, v); chk("R7", "value at threshold kept", v, 20);
    endtask

    task automatic t_clamp();
        int v;
        logic [3:0] sp;
        do_tick(sp);
        get_v(0, v); chk("R7", "second leak", v, 18);
        ev(0, 2); ev(0, 2); ev(0, 2);
        get_v(0, v); chk("R4", "negative before step", v, -3);
        do_tick(sp);
        get_v(0, v); chk("R9", "clamped to zero", v, 0);
        chk("R9", "no spike on clamp", int'(sp), 0);
    endtask

    task automatic t_saturate();
        int v;
        logic [3:0] sp;
        for (int k = 0; k < 130; k++) ev(2, 0);
        get_v(2, v); chk("R6", "positive saturation", v, 32767);
        for (int k = 0; k < 130; k++) ev(3, 2);
        get_v(3, v); chk("R6", "negative saturation", v, -32768);
        do_tick(sp);
        chk("R6", "no spike at top limit", int'(sp), 0);
        get_v(2, v); chk("R6", "negative leak saturates", v, 32767);
        get_v(3, v); chk("R9", "bottom limit clamped", v, 0);
    endtask

    task automatic t_tick_event();
        int v;
        logic [3:0] sp;
        ev(1, 0);
        get_v(1, v); chk("R4", "neuron1 charged", v, 50);
        ev_valid = 1'b1; ev_neuron = 2'd1; ev_type = 2'd0;
        do_tick(sp);
        ev_valid = 1'b0;
        chk("R10", "spike with tick event", int'(sp[1]), 1);
        get_v(1, v); chk("R10", "event kept after reset", v, 50);
    endtask

    task automatic t_cfg_mode();
        int v;
        logic [3:0] sp;
        cfg_mode = 1'b1;
        ev_valid = 1'b1; ev_neuron = 2'd2; ev_type = 2'd0;
        do_tick(sp);
        ev_valid = 1'b0;
        cfg_mode = 1'b0;
        chk("R3", "no spike in config mode", int'(sp), 0);
        for (int i = 0; i < 4; i++) begin
            get_v(i, v);
            chk("R3", "voltage forced to zero", v, 0);
        end
    endtask

    initial begin
        t_reset();
        t_config();
        t_integrate();
        t_threshold();
        t_clamp();
        t_saturate();
        t_tick_event();
        t_cfg_mode();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule